// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the master side of a local bus whose address and data share one set of lines. Each accepted request becomes one bus cycle of four T-states (T1, T2, T3, T4). A wait state (Tw) is inserted after T3 for as long as the addressed device holds READY low. The sequencer drives the address strobe, the memory/IO select, the read and write strobes, the high-byte enable and the two transceiver controls. It also drives the multiplexed lines: first the address, then the write data. For a read it returns the sampled data to the requester.

Every T-state lasts two clocks of the block's clock, a first and a second phase. A half-state event is therefore an ordinary clock edge. Such events include the falling edge of the address strobe, the late read strobe and the end of write data in mid-T4. A second master can take the bus through a HOLD/HLDA handshake. While the bus is released, every bus driver's output enable is held low.

Top module: `mux_bus_seq`

## Requirements
- R1: `ale` is high only in the first phase of T1, so it falls in mid-T1. Through both phases of T1, `ad_oe` is high, `ad_out` carries address bits [DW-1:0] and `adr_hi` carries the upper address bits.
- R2: `mio` (1 = memory, 0 = I/O) and `dtr` (1 = transmit/write, 0 = receive/read) hold the request's values from the first phase of T1 to the end of T4. Both are 0 when no cycle runs.
- R3: In a read, `ad_oe` is low from the start of T2. `rd_n` is low from the second phase of T2 until T4 begins. `rd_data` holds the `ad_in` value sampled on the edge that accepts READY, and `rd_valid` is high for exactly the first phase of T4.
- R4: In a write, `wr_n` is low from the start of T2 until T4 begins. `ad_out` carries the write data with `ad_oe` high from T2 through the first phase of T4. `rd_n` and `wr_n` are never low together.
- R5: `den` is high from the start of T2 through the first phase of T4, and low otherwise.
- R6: `bhe_n` is the inverse of `req_hi` for the whole cycle. `ad_out[0]` in T1 is address bit 0 unchanged. The pair {`bhe_n`, A0} selects the bytes: {1,0} is the low byte, {0,1} is the high byte and {0,0} is both bytes.
- R7: READY is sampled at the end of T3 and at the end of each Tw. While it is low, another two-clock Tw follows, with strobes, `den` and write data held.
- R8: `req_ack` is high only when the bus is idle or in the last phase of T4, and only while `hold` is low. A request accepted there starts T1 on the next clock, so cycles can run back to back. Requests are not accepted while the bus is released.
- R9: `hold` is sampled on every clock edge. A cycle in progress runs to the end of T4. If `hold` is high when idle or at the last phase of T4, `hlda` rises on the next clock, even if a request is pending.
- R10: While `hlda` is high, `bus_oe` and `ad_oe` are low and no strobe is active. On the first clock edge that samples `hold` low, `hlda` falls. T1 starts no earlier than the clock after that.
- R11: During and after reset the bus is idle: `ale`, `den`, `ad_oe`, `mio`, `dtr`, `rd_valid` and `hlda` are 0, `rd_n`, `wr_n` and `bhe_n` are 1, and `bus_oe` and `req_ack` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, two per T-state |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ack | output | 1 | Request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_hi | input | 1 | High byte lane wanted |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Read result |
| rd_valid | output | 1 | Read result strobe |
| ad_out | output | DW | Multiplexed address/data, driven value |
| ad_oe | output | 1 | Output enable of `ad_out` |
| ad_in | input | DW | Multiplexed lines, received value |
| adr_hi | output | AW-DW | Upper address lines |
| ale | output | 1 | Address latch strobe |
| mio | output | 1 | Memory/IO select |
| bhe_n | output | 1 | High-byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den | output | 1 | Transceiver enable |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| bus_oe | output | 1 | Output enable of address and strobe drivers |
| ready | input | 1 | Device ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus released |

## Verification
The bench builds the block with its defaults: a 20-bit address and 16-bit data lines. The four upper address bits therefore leave on their own lines while the low sixteen share lines with the data. This lets one table check that both halves of an address arrive in T1. The table holds reads and writes to memory and I/O, every byte-lane pairing, and zero to three wait states. Directed runs cover a back-to-back pair of cycles and a HOLD raised in mid-cycle while a request waits. They also cover requests offered while the bus is released and the delay before the sequencer resumes.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ack,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic          req_hi,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] adr_hi,
  output logic          ale,
  output logic          mio,
  output logic          bhe_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den,
  output logic          dtr,
  output logic          bus_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);

  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HELD} tstate_t;

  tstate_t       st;
  logic          ph;
  logic          c_wr, c_mem, c_hi;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;

  wire in_t1   = (st == S_T1);
  wire in_t2   = (st == S_T2);
  wire in_t4   = (st == S_T4);
  wire in_mid  = (st == S_T2) || (st == S_T3) || (st == S_TW);
  wire in_cyc  = in_t1 || in_mid || in_t4;
  wire t4_head = in_t4 && !ph;
  wire bound   = (st == S_IDLE) || (in_t4 && ph);

  assign req_ack = bound && !hold;

  assign hlda   = (st == S_HELD);
  assign bus_oe = !hlda;
  assign ale    = in_t1 && !ph;
  assign mio    = in_cyc && c_mem;
  assign dtr    = in_cyc && c_wr;
  assign bhe_n  = !(in_cyc && c_hi);
  assign den    = in_mid || t4_head;
  assign wr_n   = !(c_wr && in_mid);
  assign rd_n   = !(!c_wr && ((in_t2 && ph) || (st == S_T3) || (st == S_TW)));
  assign ad_oe  = in_t1 || (c_wr && (in_mid || t4_head));
  assign ad_out = in_t1 ? c_addr[DW-1:0] : c_wdata;
  assign adr_hi = c_addr[AW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      c_wr     <= 1'b0;
      c_mem    <= 1'b0;
      c_hi     <= 1'b0;
      c_addr   <= '0;
      c_wdata  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE, S_T4: begin
          if (in_t4 && !ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (hold) begin
              st <= S_HELD;
            end else if (req_valid) begin
              st      <= S_T1;
              c_wr    <= req_write;
              c_mem   <= req_mem;
              c_hi    <= req_hi;
              c_addr  <= req_addr;
              c_wdata <= req_wdata;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_T1: begin
          ph <= !ph;
          if (ph) st <= S_T2;
        end
        S_T2: begin
          ph <= !ph;
          if (ph) st <= S_T3;
        end
        S_T3, S_TW: begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (ready) begin
              st <= S_T4;
              if (!c_wr) begin
                rd_valid <= 1'b1;
                rd_data  <= ad_in;
              end
            end else begin
              st <= S_TW;
            end
          end
        end
        S_HELD: begin
          ph <= 1'b0;
          if (!hold) st <= S_IDLE;
        end
        default: begin
          st <= S_IDLE;
          ph <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic ad_oe,
  input logic rd_n,
  input logic wr_n,
  input logic den,
  input logic dtr,
  input logic mio,
  input logic hlda,
  input logic bus_oe,
  input logic hold,
  input logic ready,
  input logic req_ack,
  input logic rd_valid
);

  a_r1_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r1_ale_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && bus_oe && !den));

  a_r2_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
    den |=> ($stable(mio) && $stable(dtr)));

  a_r3_read_after_float: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!ad_oe && $past(!ad_oe) && !dtr));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));

  a_r4_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && dtr && den));

  a_r5_den_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> den);

  a_r7_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(ready));

  a_r8_ack_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !hold);

  a_r9_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold));

  a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && !ad_oe && rd_n && wr_n && !ale && !den));

  a_r10_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> ($past(!hold) && !ale));

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ad_oe(ad_oe), .rd_n(rd_n),
  .wr_n(wr_n), .den(den), .dtr(dtr), .mio(mio), .hlda(hlda),
  .bus_oe(bus_oe), .hold(hold), .ready(ready), .req_ack(req_ack),
  .rd_valid(rd_valid)
);

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NV = 6;

  // {wr, mem, hi, waits[2:0], addr[19:0], wdata[15:0], rdata[15:0]}
  localparam logic [57:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 3'd0, 20'hA1230, 16'h0000, 16'hBEEF},
    {1'b1, 1'b0, 1'b0, 3'd0, 20'h003F4, 16'h5A5A, 16'h0000},
    {1'b1, 1'b1, 1'b1, 3'd2, 20'h70001, 16'hC3C3, 16'h0000},
    {1'b0, 1'b0, 1'b1, 3'd1, 20'h00081, 16'h0000, 16'h1234},
    {1'b0, 1'b1, 1'b0, 3'd3, 20'hFFFFE, 16'h0000, 16'h0F0F},
    {1'b1, 1'b1, 1'b1, 3'd1, 20'h12340, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_hi = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ad_in = '0;
  logic ready = 1'b1, hold = 1'b0;
  logic req_ack, rd_valid, ad_oe, ale, mio, bhe_n, rd_n, wr_n, den, dtr, bus_oe, hlda;
  logic [DW-1:0] rd_data, ad_out;
  logic [AW-DW-1:0] adr_hi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mux_bus_seq #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_write(req_write), .req_mem(req_mem), .req_hi(req_hi),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .adr_hi(adr_hi), .ale(ale), .mio(mio), .bhe_n(bhe_n), .rd_n(rd_n),
    .wr_n(wr_n), .den(den), .dtr(dtr), .bus_oe(bus_oe), .ready(ready),
    .hold(hold), .hlda(hlda)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_req(input int k);
    req_write = VEC[k][57];
    req_mem   = VEC[k][56];
    req_hi    = VEC[k][55];
    req_addr  = VEC[k][51:32];
    req_wdata = VEC[k][31:16];
    req_valid = 1'b1;
  endtask

  task automatic run(input int k, input int hold_at, input int nxt);
    logic wr, mem, hi;
    int w, n;
    logic [19:0] addr;
    logic [15:0] wd, rdv;
    wr = VEC[k][57]; mem = VEC[k][56]; hi = VEC[k][55];
    w = int'(VEC[k][54:52]); addr = VEC[k][51:32];
    wd = VEC[k][31:16]; rdv = VEC[k][15:0];
    n = 8 + 2 * w;
    for (int i = 0; i < n; i++) begin
      logic t1, t2, mid, t4, odd, e_oe, e_den, e_rd, e_wr, e_rv;
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (i == hold_at) hold = 1'b1;
      odd = (i % 2) == 1;
      t1 = i < 2;
      t2 = (i >= 2) && (i < 4);
      t4 = i >= n - 2;
      mid = !t1 && !t4;
      e_den = mid || (t4 && !odd);
      e_wr = !(wr && mid);
      e_rd = !(!wr && ((t2 && odd) || (mid && !t2)));
      e_oe = t1 || (wr && e_den);
      e_rv = !wr && t4 && !odd;
      chk("R1 ale", {31'd0, ale}, {31'd0, i == 0});
      chk("R1 upper address", {28'd0, adr_hi}, {28'd0, addr[19:16]});
      chk("R2 mio/dtr", {30'd0, mio, dtr}, {30'd0, mem, wr});
      chk("R6 bhe_n", {31'd0, bhe_n}, {31'd0, !hi});
      chk("R5 den", {31'd0, den}, {31'd0, e_den});
      chk("R3 rd_n", {31'd0, rd_n}, {31'd0, e_rd});
      chk("R4 wr_n", {31'd0, wr_n}, {31'd0, e_wr});
      chk("R4 ad_oe", {31'd0, ad_oe}, {31'd0, e_oe});
      if (t1) chk("R6 address on ad_out", {16'd0, ad_out}, {16'd0, addr[15:0]});
      else if (e_oe) chk("R4 write data", {16'd0, ad_out}, {16'd0, wd});
      if (i >= 6 && !t4) chk("R7 wait state holds strobes", {29'd0, den, rd_n, wr_n}, {29'd0, 1'b1, wr, !wr});
      chk("R3 rd_valid", {31'd0, rd_valid}, {31'd0, e_rv});
      if (e_rv) chk("R3 rd_data", {16'd0, rd_data}, {16'd0, rdv});
      chk("R10 no release in cycle", {30'd0, hlda, bus_oe}, 32'd1);
      ad_in = rdv;
      ready = (i >= 5 + 2 * w);
      if (i == n - 1 && nxt >= 0) begin
        chk("R8 ack at end of T4", {31'd0, req_ack}, {31'd0, !hold});
        put_req(nxt);
      end
    end
    ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset strobes", {29'd0, ale, den, ad_oe}, 32'd0);
    chk("R11 reset active-low", {29'd0, rd_n, wr_n, bhe_n}, 32'd7);
    chk("R11 reset release", {28'd0, hlda, bus_oe, req_ack, rd_valid}, 32'b0110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {28'd0, mio, dtr, req_ack, ale}, 32'b0010);

    for (int k = 0; k < NV; k++) begin
      chk("R8 ack when idle", {31'd0, req_ack}, 32'd1);
      put_req(k);
      run(k, -1, -1);
      @(negedge clk);
    end

    put_req(0);
    run(0, -1, 1);
    run(1, -1, -1);
    @(negedge clk);

    put_req(2);
    run(2, 3, 3);
    @(negedge clk);
    chk("R9 hlda after cycle, request pending", {30'd0, hlda, ale}, 32'b10);
    chk("R10 drivers off while released", {30'd0, bus_oe, ad_oe}, 32'd0);
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk("R8 request ignored while released", {29'd0, req_ack, ale, hlda}, 32'b001);
    end
    hold = 1'b0;
    @(negedge clk);
    chk("R10 hlda falls, no T1 yet", {29'd0, hlda, ale, bus_oe}, 32'b001);
    run(3, -1, -1);
    @(negedge clk);

    hold = 1'b1;
    @(negedge clk);
    chk("R9 hlda from idle", {30'd0, hlda, req_ack}, 32'b10);
    hold = 1'b0;
    @(negedge clk);
    chk("R10 hlda low after hold drop", {30'd0, hlda, req_ack}, 32'b01);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule